// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits beside a non-volatile RAM. It watches the stream of read accesses on the 13-bit address bus and looks for a fixed run of six read addresses. When it sees the run, it asks the memory to copy the RAM into the non-volatile array (store) or to copy the non-volatile array back into the RAM (recall). Because the trigger is made only of ordinary reads, the memory needs no dedicated control pin. It keeps the pinout of a plain RAM.

The five leading addresses are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0. The sixth address picks the operation. The detector tolerates no interloper: a write, or a read of any address other than the expected next one, throws the run away. A new run then has to begin with a fresh read of 0x0000. A store is refused while the supply is out of range, but a recall is still allowed.

After the block launches an operation, it ignores the bus until the memory's busy signal is low. Every strobe is taken as one clean, already-filtered access. Outputs are registered and change on the clock edge that samples the strobe. The block has only plain control and status pins and no streaming interface, so there is no back-pressure.

Top module: `seq_unlock_detector`

## Requirements
- R1: While reset is asserted, and after it is released, `progress` is 0 and both start pulses are low.
- R2: `progress` is the number of leading addresses matched so far, 0 to 5. A read strobe of the expected next address (0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 in that order) raises it by one on that clock edge. A clock with no strobe leaves it unchanged.
- R3: With `progress` at 5, a read of 0x0F0F with `supply_ok` high raises `store_start` for exactly one cycle after that edge, and `progress` becomes 6 (launched, waiting).
- R4: With `progress` at 5, a read of 0x0F0E raises `recall_start` for exactly one cycle and sets `progress` to 6, whatever the level of `supply_ok`.
- R5: With `progress` at 5, a read of 0x0F0F while `supply_ok` is low gives no pulse and returns `progress` to 0.
- R6: A read of an unexpected address while `progress` is 1 to 5 returns `progress` to 0. This includes 0x0000 and any sixth address other than the two keys. The read that breaks the run does not count as a new first address.
- R7: A write strobe while busy is low returns `progress` to 0.
- R8: While `progress` is 0, a read of any address other than 0x0000 leaves it at 0.
- R9: While `busy` is high, read and write strobes have no effect: `progress` holds and no pulse is produced.
- R10: While `progress` is 6, all strobes are ignored. `progress` returns to 0 on the first clock edge at which `busy` is low.
- R11: A read and a write strobe in the same cycle count as a write, so R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle strobe for a completed read access |
| wr_stb | input | 1 | One-cycle strobe for a completed write access |
| addr | input | 13 | Address of the strobed access |
| busy | input | 1 | High while the memory runs a store or recall |
| supply_ok | input | 1 | High while the supply is high enough to program |
| store_start | output | 1 | One-cycle request to begin a store |
| recall_start | output | 1 | One-cycle request to begin a recall |
| progress | output | 3 | 0 to 5: leading addresses matched; 6: launched, waiting for busy low |

## Verification
A corrupted step counter shows on `progress` at the very next clock edge. The count is either off by more than one, or it fails to fall to zero after a break. A bad count can also surface later, when a correct six-read run produces no pulse or a pulse appears after five reads. A fault in the hold logic shows the cycle after a launch: `progress` leaves 6 while busy is high, or stays at 6 after busy falls. A fault in the key decode shows as the wrong pulse, or no pulse, on the edge that samples the sixth read.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int ADDR_W   = 13;
  localparam int LEAD_N   = 5;
  localparam int SEQ_LEN  = LEAD_N + 1;
  localparam int PROG_W   = $clog2(SEQ_LEN + 1);
  localparam logic [PROG_W-1:0] HOLD_CODE = PROG_W'(SEQ_LEN);
  localparam logic [ADDR_W-1:0] STORE_KEY  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] RECALL_KEY = 13'h0F0E;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_ADV,
    EV_BREAK,
    EV_STORE,
    EV_RECALL
  } unlock_ev_t;

  function automatic logic [ADDR_W-1:0] lead_addr(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/unlock_expect.sv
module unlock_expect
  import unlock_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PROG_W
) (
  input  logic [PW-1:0] step,
  output logic [AW-1:0] exp_addr,
  output logic          at_last
);
  logic [AW-1:0] lead_tab [LEAD_N];

  for (genvar g = 0; g < LEAD_N; g++) begin : g_lead
    assign lead_tab[g] = AW'(lead_addr(g));
  end

  always_comb begin
    exp_addr = '0;
    for (int i = 0; i < LEAD_N; i++) begin
      if (step == PW'(i)) exp_addr = lead_tab[i];
    end
  end

  assign at_last = (step == PW'(LEAD_N));
endmodule

// File: rtl/unlock_classify.sv
module unlock_classify
  import unlock_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] exp_addr,
  input  logic          at_last,
  output unlock_ev_t    ev
);
  always_comb begin
    ev = EV_NONE;
    if (busy) begin
      ev = EV_NONE;
    end else if (wr_stb) begin
      ev = EV_BREAK;
    end else if (rd_stb) begin
      if (at_last) begin
        if (addr == AW'(STORE_KEY))       ev = EV_STORE;
        else if (addr == AW'(RECALL_KEY)) ev = EV_RECALL;
        else                              ev = EV_BREAK;
      end else if (addr == exp_addr) begin
        ev = EV_ADV;
      end else begin
        ev = EV_BREAK;
      end
    end
  end
endmodule

// File: rtl/unlock_tracker.sv
module unlock_tracker
  import unlock_pkg::*;
#(
  parameter int PW = PROG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  unlock_ev_t    ev,
  input  logic          busy,
  input  logic          supply_ok,
  output logic [PW-1:0] step,
  output logic          hold,
  output logic          store_start,
  output logic          recall_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step         <= '0;
      hold         <= 1'b0;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      store_start  <= 1'b0;
      recall_start <= 1'b0;
      if (hold) begin
        if (!busy) hold <= 1'b0;
      end else begin
        case (ev)
          EV_ADV:   step <= step + PW'(1);
          EV_BREAK: step <= '0;
          EV_STORE: begin
            step <= '0;
            if (supply_ok) begin
              store_start <= 1'b1;
              hold        <= 1'b1;
            end
          end
          EV_RECALL: begin
            step         <= '0;
            recall_start <= 1'b1;
            hold         <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/seq_unlock_detector.sv
module seq_unlock_detector
  import unlock_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PROG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic          supply_ok,
  output logic          store_start,
  output logic          recall_start,
  output logic [PW-1:0] progress
);
  logic [PW-1:0] step;
  logic          hold;
  logic [AW-1:0] exp_addr;
  logic          at_last;
  unlock_ev_t    ev;

  unlock_expect #(.AW(AW), .PW(PW)) u_expect (
    .step     (step),
    .exp_addr (exp_addr),
    .at_last  (at_last)
  );

  unlock_classify #(.AW(AW)) u_classify (
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .busy     (busy),
    .addr     (addr),
    .exp_addr (exp_addr),
    .at_last  (at_last),
    .ev       (ev)
  );

  unlock_tracker #(.PW(PW)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev           (ev),
    .busy         (busy),
    .supply_ok    (supply_ok),
    .step         (step),
    .hold         (hold),
    .store_start  (store_start),
    .recall_start (recall_start)
  );

  assign progress = hold ? PW'(HOLD_CODE) : step;
endmodule

// File: rtl/unlock_chk.sv
module unlock_chk
  import unlock_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PROG_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          supply_ok,
  input logic          store_start,
  input logic          recall_start,
  input logic [PW-1:0] progress
);
  // R3
  store_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> ($past(rd_stb) && !$past(wr_stb) && !$past(busy) && $past(supply_ok)
                     && $past(addr) == AW'(STORE_KEY) && $past(progress) == PW'(LEAD_N)));

  // R4
  recall_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> ($past(rd_stb) && !$past(wr_stb) && !$past(busy)
                      && $past(addr) == AW'(RECALL_KEY) && $past(progress) == PW'(LEAD_N)));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |=> !(store_start || recall_start));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (progress != '0 && progress != $past(progress)) |-> progress == PW'($past(progress) + PW'(1)));

  // R7
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy && progress != '0 && progress != PW'(HOLD_CODE)) |=> progress == '0);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && progress != PW'(HOLD_CODE)) |=> ($stable(progress) && !store_start && !recall_start));

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (progress == PW'(HOLD_CODE) && !busy) |=> progress == '0);

  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    progress <= PW'(HOLD_CODE));
endmodule

bind seq_unlock_detector unlock_chk #(.AW(AW), .PW(PW)) u_unlock_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb),
  .addr         (addr),
  .busy         (busy),
  .supply_ok    (supply_ok),
  .store_start  (store_start),
  .recall_start (recall_start),
  .progress     (progress)
);

// File: tb/test_seq_unlock_detector.sv
module test_seq_unlock_detector;
  localparam int CLK_P = 10;
  localparam int NV    = 52;
  // fields: req[25:22] rd[21] wr[20] busy[19] sup[18] addr[17:5] prog[4:2] st[1] rc[0]
  localparam logic [25:0] VEC [NV] = '{
    // R2 leading reads, then R3 store launch, R10 hold
    {4'd2, 4'b1001, 13'h0000, 5'b001_00},
    {4'd2, 4'b1001, 13'h1555, 5'b010_00},
    {4'd2, 4'b1001, 13'h0AAA, 5'b011_00},
    {4'd2, 4'b1001, 13'h1FFF, 5'b100_00},
    {4'd2, 4'b1001, 13'h10F0, 5'b101_00},
    {4'd3, 4'b1001, 13'h0F0F, 5'b110_10},
    {4'd10, 4'b0011, 13'h0000, 5'b110_00},
    {4'd10, 4'b1011, 13'h0000, 5'b110_00},
    {4'd10, 4'b0001, 13'h0000, 5'b000_00},
    // R4 recall with supply low
    {4'd2, 4'b1000, 13'h0000, 5'b001_00},
    {4'd2, 4'b1000, 13'h1555, 5'b010_00},
    {4'd2, 4'b1000, 13'h0AAA, 5'b011_00},
    {4'd2, 4'b1000, 13'h1FFF, 5'b100_00},
    {4'd2, 4'b1000, 13'h10F0, 5'b101_00},
    {4'd4, 4'b1000, 13'h0F0E, 5'b110_01},
    {4'd9, 4'b0010, 13'h0000, 5'b110_00},
    {4'd10, 4'b0000, 13'h0000, 5'b000_00},
    // R5 store refused with supply low
    {4'd2, 4'b1000, 13'h0000, 5'b001_00},
    {4'd2, 4'b1000, 13'h1555, 5'b010_00},
    {4'd2, 4'b1000, 13'h0AAA, 5'b011_00},
    {4'd2, 4'b1000, 13'h1FFF, 5'b100_00},
    {4'd2, 4'b1000, 13'h10F0, 5'b101_00},
    {4'd5, 4'b1000, 13'h0F0F, 5'b000_00},
    // R8 idle ignores other reads; R6 breaks
    {4'd8, 4'b1001, 13'h1555, 5'b000_00},
    {4'd6, 4'b1001, 13'h0000, 5'b001_00},
    {4'd6, 4'b1001, 13'h1555, 5'b010_00},
    {4'd6, 4'b1001, 13'h0000, 5'b000_00},
    {4'd6, 4'b1001, 13'h1555, 5'b000_00},
    // R7 write abort
    {4'd7, 4'b1001, 13'h0000, 5'b001_00},
    {4'd7, 4'b0101, 13'h1555, 5'b000_00},
    // R9 busy ignores strobes mid-run
    {4'd9, 4'b1001, 13'h0000, 5'b001_00},
    {4'd9, 4'b1011, 13'h1234, 5'b001_00},
    {4'd9, 4'b0111, 13'h0000, 5'b001_00},
    {4'd9, 4'b1001, 13'h1555, 5'b010_00},
    {4'd2, 4'b0001, 13'h0000, 5'b010_00},
    {4'd2, 4'b1001, 13'h0AAA, 5'b011_00},
    {4'd6, 4'b1001, 13'h0AAA, 5'b000_00},
    // R6 wrong sixth address
    {4'd2, 4'b1001, 13'h0000, 5'b001_00},
    {4'd2, 4'b1001, 13'h1555, 5'b010_00},
    {4'd2, 4'b1001, 13'h0AAA, 5'b011_00},
    {4'd2, 4'b1001, 13'h1FFF, 5'b100_00},
    {4'd2, 4'b1001, 13'h10F0, 5'b101_00},
    {4'd6, 4'b1001, 13'h0F0D, 5'b000_00},
    // R11 read and write together
    {4'd11, 4'b1101, 13'h0000, 5'b000_00},
    // R9 sixth read during busy ignored, then R3 store
    {4'd2, 4'b1001, 13'h0000, 5'b001_00},
    {4'd2, 4'b1001, 13'h1555, 5'b010_00},
    {4'd2, 4'b1001, 13'h0AAA, 5'b011_00},
    {4'd2, 4'b1001, 13'h1FFF, 5'b100_00},
    {4'd2, 4'b1001, 13'h10F0, 5'b101_00},
    {4'd9, 4'b1011, 13'h0F0F, 5'b101_00},
    {4'd3, 4'b1001, 13'h0F0F, 5'b110_10},
    {4'd10, 4'b0001, 13'h0000, 5'b000_00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [12:0] addr = '0;
  logic        busy = 1'b0;
  logic        supply_ok = 1'b1;
  logic        store_start;
  logic        recall_start;
  logic [2:0]  progress;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  seq_unlock_detector i_seq_unlock_detector (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .addr         (addr),
    .busy         (busy),
    .supply_ok    (supply_ok),
    .store_start  (store_start),
    .recall_start (recall_start),
    .progress     (progress)
  );

  task automatic check(input int req, input logic [4:0] exp);
    logic [4:0] act;
    act = {progress, store_start, recall_start};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: {progress,store,recall} actual %b_%b%b expected %b_%b%b",
               req, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [12:0] a);
    {rd_stb, wr_stb, busy, supply_ok} = ctl;
    addr = a;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(1, 5'b000_00);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 5'b000_00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:18], VEC[i][17:5]);
      @(negedge clk);
      check(int'(VEC[i][25:22]), VEC[i][4:0]);
    end

    // R1: reset in the middle of a run
    drive(4'b1001, 13'h0000);
    @(negedge clk);
    drive(4'b1001, 13'h1555);
    @(negedge clk);
    check(2, 5'b010_00);
    drive(4'b0001, 13'h0000);
    rst_n = 1'b0;
    #1;
    check(1, 5'b000_00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b1001, 13'h0AAA);
    @(negedge clk);
    check(1, 5'b000_00);
    drive(4'b0001, 13'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule